// File: doc/BRIEF.md
# Serial Control Word Receiver for a Six-Channel Volume and Tone Controller

This block takes 16-bit control words from a three-wire serial port (serial clock, serial data, latch) and keeps the setting registers of a six-channel audio attenuator with a stereo tone stage. All three serial lines are asynchronous to the system clock. A two-flop synchroniser and an edge detector bring them into the system clock domain. While the latch line is low, each rising edge of the serial clock shifts one data bit into a word register, D0 first.

A rising latch commits the word. The last two bits of the word (DE, DF) name one of four register pairs. The pair is either treble, bass and the bypass flag, or two 7-bit channel attenuation codes. The word is accepted only when exactly sixteen bits were shifted since the previous latch edge. Any other count discards it.

Each volume channel also has a decoded mute flag. The code space has two separate full-mute regions, and the flag reports both. A one-cycle strobe and a 2-bit slot number announce every accepted word.

Top module: `volctl_serial_rx`

## Requirements
- R1: Bits are taken only on a rising edge of `ser_clk_i` while `ser_lat_i` is low. The first bit shifted is D0 and the sixteenth is DF.
- R2: Rising edges of `ser_clk_i` while `ser_lat_i` is high shift nothing and are not counted. A correct 16-bit word that follows such edges is committed unaltered.
- R3: On a rising `ser_lat_i`, the slot value {DE,DF} (DE is the high bit) selects the target. Slot 0 is treble, bass and bypass. Slot 1 is the L and R volumes, slot 2 the C and SW volumes, and slot 3 the SL and SR volumes.
- R4: In a volume word, D0..D6 is the first channel's 7-bit code with D0 as the MSB. D7..DD is the second channel's code with D7 as the MSB.
- R5: In a tone word, D0..D3 is the treble code with D0 as the MSB, and D8..DB is the bass code with D8 as the MSB. DD is the bypass flag: 1 is bypass, 0 is the tone path.
- R6: `mute[i]` is 1 exactly when the channel code lies in 80..95 or 112..127. Codes 0..79 and 96..111 give 0. The bit order is L, R, C, SW, SL, SR from bit 0.
- R7: A latch rise that follows 0 to 15, or more than 16, counted bits changes no register and gives no strobe.
- R8: A synchronous reset sets all six volume codes to 127 (so all mute flags are 1). It sets treble and bass to 0 (flat), bypass to 0 and `upd` to 0.
- R9: For an accepted word, the new values and a single-cycle `upd` with `upd_slot` equal to the slot appear on the third rising system clock edge after `ser_lat_i` goes high.
- R10: A committed word leaves every register outside its addressed pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_lat_i | input | 1 | Latch; low while shifting, rising edge commits |
| att_l | output | 7 | Left channel attenuation code |
| att_r | output | 7 | Right channel attenuation code |
| att_c | output | 7 | Centre channel attenuation code |
| att_sw | output | 7 | Subwoofer channel attenuation code |
| att_sl | output | 7 | Surround-left attenuation code |
| att_sr | output | 7 | Surround-right attenuation code |
| treble | output | 4 | Treble setting code |
| bass | output | 4 | Bass setting code |
| bypass | output | 1 | 1 = tone stage bypassed |
| mute | output | 6 | Per-channel full-mute flags |
| upd | output | 1 | One-cycle strobe per committed word |
| upd_slot | output | 2 | Slot of the last committed word |

## Verification
The assertions assume a slow serial port. Each high and low phase of `ser_clk_i`, and each level of `ser_lat_i`, lasts at least two system clocks, so the synchroniser sees every edge. Data is stable around each serial clock rise, and the latch never rises in the same synchronised cycle as a serial clock rise. The stimulus holds each serial phase for two or three system cycles and changes data only while the serial clock is low. It waits several cycles between the last clock fall and the latch rise. The reference model in the bench decodes fields from its own bit list and predicts the commit cycle from the moment it raised the latch.

// File: rtl/volctl_pkg.sv
package volctl_pkg;
  localparam int WORD_W = 16;
  localparam int VOL_W  = 7;
  localparam int TONE_W = 4;
  localparam int NCH    = 6;
  localparam int SLOT_W = 2;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_TONE  = 2'd0,
    SLOT_FRONT = 2'd1,
    SLOT_CTR   = 2'd2,
    SLOT_SURR  = 2'd3
  } slot_e;

  // Shift register holds D0 in the MSB and DF in the LSB.
  function automatic logic [SLOT_W-1:0] word_slot(input logic [WORD_W-1:0] w);
    return w[SLOT_W-1:0];
  endfunction

  function automatic logic [VOL_W-1:0] vol_first(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: VOL_W];
  endfunction

  function automatic logic [VOL_W-1:0] vol_second(input logic [WORD_W-1:0] w);
    return w[WORD_W-1-VOL_W -: VOL_W];
  endfunction

  function automatic logic [TONE_W-1:0] tone_treble(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: TONE_W];
  endfunction

  function automatic logic [TONE_W-1:0] tone_bass(input logic [WORD_W-1:0] w);
    return w[WORD_W-9 -: TONE_W];
  endfunction

  function automatic logic tone_bypass(input logic [WORD_W-1:0] w);
    return w[SLOT_W];
  endfunction

  // Mute regions: 80..95 (101xxxx) and 112..127 (111xxxx).
  function automatic logic vol_is_mute(input logic [VOL_W-1:0] c);
    return (c[VOL_W-1 -: 3] == 3'b101) || (c[VOL_W-1 -: 3] == 3'b111);
  endfunction
endpackage

// File: rtl/vc_sync_edge.sv
module vc_sync_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] pipe [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
endmodule

// File: rtl/vc_shift_rx.sv
module vc_shift_rx
  import volctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_rise,
  input  logic              lat_lvl,
  input  logic              lat_rise,
  input  logic              dat_lvl,
  output logic [WORD_W-1:0] sh_word,
  output logic              commit
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             take_bit;

  assign take_bit = clk_rise && !lat_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      sh_word <= '0;
    end else if (lat_rise) begin
      bit_cnt <= '0;
    end else if (take_bit) begin
      sh_word <= {sh_word[WORD_W-2:0], dat_lvl};
      if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit = lat_rise && (bit_cnt == CNT_FULL);
endmodule

// File: rtl/vc_regbank.sv
module vc_regbank
  import volctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   commit,
  input  logic [WORD_W-1:0]      word,
  output logic [NCH*VOL_W-1:0]   vol_flat,
  output logic [NCH-1:0]         mute,
  output logic [TONE_W-1:0]      treble,
  output logic [TONE_W-1:0]      bass,
  output logic                   bypass,
  output logic                   upd,
  output logic [SLOT_W-1:0]      upd_slot
);
  localparam logic [VOL_W-1:0] VOL_RST = '1;

  logic [SLOT_W-1:0] slot;
  assign slot = word_slot(word);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(ch / 2 + 1);
    logic [VOL_W-1:0] code;
    always_ff @(posedge clk) begin
      if (rst) code <= VOL_RST;
      else if (commit && slot == MY_SLOT)
        code <= (ch % 2 == 0) ? vol_first(word) : vol_second(word);
    end
    assign vol_flat[ch*VOL_W +: VOL_W] = code;
    assign mute[ch] = vol_is_mute(code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      treble <= '0;
      bass   <= '0;
      bypass <= 1'b0;
    end else if (commit && slot == SLOT_TONE) begin
      treble <= tone_treble(word);
      bass   <= tone_bass(word);
      bypass <= tone_bypass(word);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd      <= 1'b0;
      upd_slot <= '0;
    end else begin
      upd <= commit;
      if (commit) upd_slot <= slot;
    end
  end
endmodule

// File: rtl/volctl_serial_rx.sv
module volctl_serial_rx
  import volctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk_i,
  input  logic                ser_dat_i,
  input  logic                ser_lat_i,
  output logic [VOL_W-1:0]    att_l,
  output logic [VOL_W-1:0]    att_r,
  output logic [VOL_W-1:0]    att_c,
  output logic [VOL_W-1:0]    att_sw,
  output logic [VOL_W-1:0]    att_sl,
  output logic [VOL_W-1:0]    att_sr,
  output logic [TONE_W-1:0]   treble,
  output logic [TONE_W-1:0]   bass,
  output logic                bypass,
  output logic [NCH-1:0]      mute,
  output logic                upd,
  output logic [SLOT_W-1:0]   upd_slot
);
  logic [2:0] in_lvl, in_rise;
  logic       clk_rise, lat_lvl, lat_rise, dat_lvl;
  logic [WORD_W-1:0]    sh_word;
  logic                 commit;
  logic [NCH*VOL_W-1:0] vol_flat;

  vc_sync_edge #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d    ({ser_lat_i, ser_dat_i, ser_clk_i}),
    .lvl  (in_lvl),
    .rise (in_rise)
  );

  assign clk_rise = in_rise[0];
  assign dat_lvl  = in_lvl[1];
  assign lat_lvl  = in_lvl[2];
  assign lat_rise = in_rise[2];

  vc_shift_rx u_shift (
    .clk      (clk),
    .rst      (rst),
    .clk_rise (clk_rise),
    .lat_lvl  (lat_lvl),
    .lat_rise (lat_rise),
    .dat_lvl  (dat_lvl),
    .sh_word  (sh_word),
    .commit   (commit)
  );

  vc_regbank u_regs (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit),
    .word     (sh_word),
    .vol_flat (vol_flat),
    .mute     (mute),
    .treble   (treble),
    .bass     (bass),
    .bypass   (bypass),
    .upd      (upd),
    .upd_slot (upd_slot)
  );

  assign att_l  = vol_flat[0*VOL_W +: VOL_W];
  assign att_r  = vol_flat[1*VOL_W +: VOL_W];
  assign att_c  = vol_flat[2*VOL_W +: VOL_W];
  assign att_sw = vol_flat[3*VOL_W +: VOL_W];
  assign att_sl = vol_flat[4*VOL_W +: VOL_W];
  assign att_sr = vol_flat[5*VOL_W +: VOL_W];
endmodule

// File: rtl/vc_rx_chk.sv
module vc_rx_chk
  import volctl_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 clk_rise,
  input logic                 lat_lvl,
  input logic                 commit,
  input logic [WORD_W-1:0]    sh_word,
  input logic [NCH*VOL_W-1:0] vol_flat,
  input logic [TONE_W-1:0]    treble,
  input logic [TONE_W-1:0]    bass,
  input logic                 bypass,
  input logic                 upd,
  input logic [SLOT_W-1:0]    upd_slot
);
  a_r8_reset_values: assert property (@(posedge clk)
    rst |=> (vol_flat == {NCH*VOL_W{1'b1}} && treble == '0 && bass == '0 && !bypass && !upd));

  a_r9_strobe_has_cause: assert property (@(posedge clk) disable iff (rst)
    upd |-> $past(commit));

  a_r9_commit_strobes: assert property (@(posedge clk) disable iff (rst)
    commit |=> upd);

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !upd |-> ($stable(vol_flat) && $stable(treble) && $stable(bass) && $stable(bypass)));

  a_r10_tone_isolated: assert property (@(posedge clk) disable iff (rst)
    (upd && upd_slot != SLOT_TONE) |-> ($stable(treble) && $stable(bass) && $stable(bypass)));

  a_r10_front_isolated: assert property (@(posedge clk) disable iff (rst)
    (upd && upd_slot != SLOT_FRONT) |-> $stable(vol_flat[2*VOL_W-1:0]));

  a_r10_vol_isolated_on_tone: assert property (@(posedge clk) disable iff (rst)
    (upd && upd_slot == SLOT_TONE) |-> $stable(vol_flat));

  a_r2_no_shift_latch_high: assert property (@(posedge clk) disable iff (rst)
    (clk_rise && lat_lvl) |=> $stable(sh_word));
endmodule

bind volctl_serial_rx vc_rx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_rise (clk_rise),
  .lat_lvl  (lat_lvl),
  .commit   (commit),
  .sh_word  (sh_word),
  .vol_flat (vol_flat),
  .treble   (treble),
  .bass     (bass),
  .bypass   (bypass),
  .upd      (upd),
  .upd_slot (upd_slot)
);

// File: tb/test_volctl_serial_rx.sv
module test_volctl_serial_rx;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, slat = 1'b1;
  logic [6:0] att_l, att_r, att_c, att_sw, att_sl, att_sr;
  logic [3:0] treble, bass;
  logic       bypass, upd;
  logic [5:0] mute;
  logic [1:0] upd_slot;

  always #5 clk = ~clk;

  volctl_serial_rx i_volctl_serial_rx (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_lat_i(slat),
    .att_l(att_l), .att_r(att_r), .att_c(att_c), .att_sw(att_sw),
    .att_sl(att_sl), .att_sr(att_sr), .treble(treble), .bass(bass),
    .bypass(bypass), .mute(mute), .upd(upd), .upd_slot(upd_slot)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int e_vol[6];
  int e_tre = 0, e_bas = 0, e_byp = 0, e_upd = 0, e_slot = 0;
  int q_due[$];
  int q_word[$];
  bit cmp_on = 0, done = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int dbit(int w, int i);
    return (w >> i) & 1;
  endfunction

  function automatic int bench_mute(int c);
    return ((c >= 80 && c <= 95) || c >= 112) ? 1 : 0;
  endfunction

  // Bench word: bit i holds Di.
  function automatic int mk_vol(int slot, int a, int b);
    int w = 0;
    for (int k = 0; k < 7; k++) begin
      w |= ((a >> (6 - k)) & 1) << k;
      w |= ((b >> (6 - k)) & 1) << (7 + k);
    end
    w |= ((slot >> 1) & 1) << 14;
    w |= (slot & 1) << 15;
    return w;
  endfunction

  function automatic int mk_tone(int tre, int bas, int byp);
    int w = 0;
    for (int k = 0; k < 4; k++) begin
      w |= ((tre >> (3 - k)) & 1) << k;
      w |= ((bas >> (3 - k)) & 1) << (8 + k);
    end
    w |= (byp & 1) << 13;
    return w;
  endfunction

  task automatic model_apply(int w);
    int slot, a, b;
    slot = dbit(w, 14) * 2 + dbit(w, 15);
    if (slot == 0) begin
      e_tre = 0; e_bas = 0;
      for (int k = 0; k < 4; k++) begin
        e_tre += dbit(w, k) << (3 - k);
        e_bas += dbit(w, 8 + k) << (3 - k);
      end
      e_byp = dbit(w, 13);
    end else begin
      a = 0; b = 0;
      for (int k = 0; k < 7; k++) begin
        a += dbit(w, k) << (6 - k);
        b += dbit(w, 7 + k) << (6 - k);
      end
      e_vol[2*(slot-1)]   = a;
      e_vol[2*(slot-1)+1] = b;
    end
    e_upd = 1;
    e_slot = slot;
  endtask

  // Per-cycle comparison against the reference model.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      e_upd = 0;
      while (q_due.size() > 0 && q_due[0] == cyc) begin
        model_apply(q_word[0]);
        void'(q_due.pop_front());
        void'(q_word.pop_front());
      end
      check("R4 att_l",  att_l,  e_vol[0]);
      check("R4 att_r",  att_r,  e_vol[1]);
      check("R4 att_c",  att_c,  e_vol[2]);
      check("R4 att_sw", att_sw, e_vol[3]);
      check("R4 att_sl", att_sl, e_vol[4]);
      check("R4 att_sr", att_sr, e_vol[5]);
      for (int i = 0; i < 6; i++) check("R6 mute", mute[i], bench_mute(e_vol[i]));
      check("R5 treble", treble, e_tre);
      check("R5 bass",   bass,   e_bas);
      check("R5 bypass", bypass, e_byp);
      check("R9 upd",    upd,    e_upd);
      if (e_upd == 1) check("R9 upd_slot", upd_slot, e_slot);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  task automatic send(int w, int n);
    int c;
    slat = 1'b0;
    tick(3);
    for (int i = 0; i < n; i++) begin
      sdat = dbit(w, i % 16);
      tick(2);
      sclk = 1'b1;
      tick(3);
      sclk = 1'b0;
      tick(2);
    end
    tick(2);
    slat = 1'b1;
    c = cyc;
    if (n == 16) begin
      q_due.push_back(c + 3);
      q_word.push_back(w);
    end
    tick(3);
    check((n == 16) ? "R9 strobe" : "R7 no strobe", upd, (n == 16) ? 1 : 0);
    if (n == 16) check("R3 slot id", upd_slot, dbit(w, 14) * 2 + dbit(w, 15));
    tick(1);
    check("R9 single cycle", upd, 0);
    tick(4);
  endtask

  task automatic noise(int k);
    for (int i = 0; i < k; i++) begin
      sdat = i[0];
      tick(2);
      sclk = 1'b1;
      tick(3);
      sclk = 1'b0;
      tick(2);
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) e_vol[i] = 127;
    tick(5);
    rst = 1'b0;
    cmp_on = 1;
    tick(1);
    check("R8 att_l", att_l, 127);
    check("R8 att_sr", att_sr, 127);
    check("R8 mute", mute, 63);
    check("R8 treble", treble, 0);
    check("R8 bypass", bypass, 0);
    check("R8 upd", upd, 0);
    tick(6);

    send(mk_vol(1, 0, 79), 16);
    check("R1 first bit is D0 (att_l)", att_l, 0);
    check("R3 slot1 att_r", att_r, 79);
    check("R6 no mute at 0/79", mute[1:0], 0);

    send(mk_vol(2, 80, 95), 16);
    check("R6 mute at 80/95", mute[3:2], 3);
    check("R10 att_l kept", att_l, 0);

    send(mk_vol(3, 96, 111), 16);
    check("R4 att_sl", att_sl, 96);
    check("R6 no mute 96/111", mute[5:4], 0);

    send(mk_vol(3, 112, 85), 16);
    check("R6 mute 112/85", mute[5:4], 3);

    send(mk_vol(1, 1, 64), 16);
    check("R4 msb first att_l", att_l, 1);
    check("R4 msb first att_r", att_r, 64);

    send(mk_tone(11, 6, 1), 16);
    check("R5 treble", treble, 11);
    check("R5 bass", bass, 6);
    check("R5 bypass set", bypass, 1);
    check("R10 att_r kept", att_r, 64);

    send(mk_tone(1, 14, 0), 16);
    check("R5 bypass clear", bypass, 0);
    check("R5 bass 14", bass, 14);

    send(mk_vol(1, 33, 44), 15);
    check("R7 short word", att_l, 1);
    send(mk_vol(1, 33, 44), 17);
    check("R7 long word", att_r, 64);
    send(0, 0);
    check("R7 empty word", treble, 1);

    noise(5);
    send(mk_vol(2, 7, 120), 16);
    check("R2 att_c after ignored clocks", att_c, 7);
    check("R2 att_sw after ignored clocks", att_sw, 120);

    tick(10);
    done = 1;
    summary();
  end
endmodule